// File: doc/BRIEF.md
# Serial Byte Link Status and Interrupt Controller

This block holds the software-visible control, status and interrupt-mask state of a serial byte link. A bus master enables the transmitter and receiver, loads bytes for transmission and collects received bytes through a small register file. A shifter beside the block, which is not part of it, reports single-cycle events: it took the held byte into its shift register, it finished shifting, or it completed a byte on the receive side, with parity and framing indications.

The block keeps two transmit flags. The holding buffer can be empty while the shifter is still busy, and a transfer counts as complete only when both the holding-buffer-empty flag and the shift-empty flag are set. On the receive side it keeps a buffer-full flag and three error flags, plus a summary error that is the OR of the three. A read of the receive data register returns the byte and clears the full flag and every receive error. A second error view shows the error flags at the same bit positions, and software can clear them selectively by writing zeros to it. One interrupt output combines the masked status sources.

Top module: `sir_uart_status`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x03 (both transmit flags set), the mask reads 0, and `irq` is low.
- R2: Register 0 (control) holds transmit enable at bit 0 and receive enable at bit 1. Writing 1 to bit 2 discards the held transmit byte and sets the holding-empty flag. Bit 2 always reads back as 0.
- R3: A write to register 3 (transmit data) while transmit is enabled stores the byte and clears status bit 0. `tx_valid` is then high with `tx_byte` equal to the byte. The same write with transmit disabled has no effect.
- R4: `sh_take` sets status bit 0 and clears status bit 1 (shift empty). `sh_done` sets bit 1. If a transmit data write falls in the same cycle as `sh_take`, the write wins for bit 0. If `sh_take` and `sh_done` coincide, `sh_take` wins for bit 1.
- R5: `rx_stb` with receive enabled sets status bit 2 (buffer full) and makes the byte readable in register 4, bits 7:0. With receive disabled the strobe and its error inputs are ignored.
- R6: `rx_par_err` and `rx_frm_err`, sampled with `rx_stb`, set status bits 3 and 4. Bit 6 (sum) is set whenever any of bits 3, 4 or 5 is set.
- R7: `rx_stb` while bit 2 is set and register 4 is not being read in that cycle sets bit 5 (overrun) and keeps the old byte.
- R8: A read of register 4 clears bit 2 and bits 3 to 6. If a new byte arrives in the same cycle, the new byte is stored with bit 2 set and no overrun.
- R9: Register 2 shows bits 3 to 6 of the status register at the same positions, with all other bits 0. A write to it clears each of bits 3 to 5 that is written 0 and leaves each one written 1 unchanged.
- R10: Register 5 (mask) stores bits 0, 1, 2 and 6 and reads 0 elsewhere.
- R11: `irq` is the OR of the status bits ANDed with their mask bits. Bits 0 and 1 count only while transmit is enabled, and bits 2 and 6 only while receive is enabled. With `IRQ_REG`=0, `irq` follows the flags in the same cycle they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read side effects) |
| bus_sel | input | ADDR_W | Register select |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for the selected register, combinational |
| rx_stb | input | 1 | Received byte complete, one cycle |
| rx_byte | input | DATA_W | Received byte |
| rx_par_err | input | 1 | Parity error for the byte on `rx_stb` |
| rx_frm_err | input | 1 | Framing error for the byte on `rx_stb` |
| sh_take | input | 1 | Shifter loaded the held transmit byte |
| sh_done | input | 1 | Shifter finished the last bit |
| tx_valid | output | 1 | A transmit byte is held and transmit is enabled |
| tx_byte | output | DATA_W | Held transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Every flag, register and `tx_byte` changes on the clock edge that samples the strobe. `bus_rdata` and `irq` are combinational from that state, so each result can be seen one edge after its stimulus. The bench drives stimulus at the falling edge, drops the strobes at the next falling edge, and samples the status view and `irq` a moment later. A read with side effects is therefore never mistaken for an observation. Same-cycle collisions (read with a new byte, take with a write) are applied in a single cycle, and their results are checked at the following falling edge.

// File: rtl/sir_uart_pkg.sv
package sir_uart_pkg;
   localparam int SEL_CTRL = 0;
   localparam int SEL_STAT = 1;
   localparam int SEL_ERRV = 2;
   localparam int SEL_TXD  = 3;
   localparam int SEL_RXD  = 4;
   localparam int SEL_MASK = 5;

   localparam int B_TBE  = 0;
   localparam int B_TSBE = 1;
   localparam int B_RBF  = 2;
   localparam int B_PAR  = 3;
   localparam int B_FRM  = 4;
   localparam int B_OVR  = 5;
   localparam int B_SUM  = 6;

   localparam int STAT_W = 7;
   localparam logic [STAT_W-1:0] MASK_IMPL = 7'h47;

   typedef struct packed {
      logic sum;
      logic ovr;
      logic frm;
      logic par;
   } rx_err_t;
endpackage

// File: rtl/sir_uart_tx_flags.sv
module sir_uart_tx_flags #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_wdata,
   input  logic              tx_flush,
   input  logic              sh_take,
   input  logic              sh_done,
   output logic              tbe,
   output logic              tsbe,
   output logic [DATA_W-1:0] hold
);
   logic load;
   assign load = tx_wr && tx_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbe  <= 1'b1;
         tsbe <= 1'b1;
         hold <= '0;
      end else begin
         if (load) begin
            tbe  <= 1'b0;
            hold <= tx_wdata;
         end else if (sh_take || tx_flush) begin
            tbe  <= 1'b1;
         end
         if (sh_take)      tsbe <= 1'b0;
         else if (sh_done) tsbe <= 1'b1;
      end
   end

   a_r4_take_sets_tbe: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_take && !load) |=> (tbe && !tsbe));
   a_r3_load_clears_tbe: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!tbe && hold == $past(tx_wdata)));
   a_r3_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en) |=> $stable(hold));
endmodule

// File: rtl/sir_uart_rx_flags.sv
module sir_uart_rx_flags
   import sir_uart_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rx_stb,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              par_in,
   input  logic              frm_in,
   input  logic              rd_clr,
   input  logic              err_wr,
   input  logic [2:0]        err_keep,   // {ovr,frm,par}, 0 clears
   output logic              rbf,
   output rx_err_t           err,
   output logic [DATA_W-1:0] hold
);
   logic par_q, frm_q, ovr_q;
   logic take, full_eff;
   logic par_n, frm_n, ovr_n;

   assign take     = rx_stb && rx_en;
   assign full_eff = rbf && !rd_clr;

   always_comb begin
      par_n = par_q && !rd_clr;
      frm_n = frm_q && !rd_clr;
      ovr_n = ovr_q && !rd_clr;
      if (err_wr) begin
         par_n = par_n && err_keep[0];
         frm_n = frm_n && err_keep[1];
         ovr_n = ovr_n && err_keep[2];
      end
      if (take) begin
         par_n = par_n || par_in;
         frm_n = frm_n || frm_in;
         ovr_n = ovr_n || full_eff;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbf   <= 1'b0;
         hold  <= '0;
         par_q <= 1'b0;
         frm_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         par_q <= par_n;
         frm_q <= frm_n;
         ovr_q <= ovr_n;
         if (take && !full_eff) begin
            rbf  <= 1'b1;
            hold <= rx_byte;
         end else if (rd_clr) begin
            rbf  <= 1'b0;
         end
      end
   end

   assign err = '{sum: (par_q | frm_q | ovr_q), ovr: ovr_q, frm: frm_q, par: par_q};

   a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rbf && !rd_clr) |=> (ovr_q && rbf && $stable(hold)));
   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !take && !err_wr) |=> (!rbf && !par_q && !frm_q && !ovr_q));
   a_r8_read_and_new: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && take) |=> (rbf && hold == $past(rx_byte)));
endmodule

// File: rtl/sir_uart_irq.sv
module sir_uart_irq
   import sir_uart_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] stat,
   input  logic [STAT_W-1:0] mask,
   input  logic              tx_en,
   input  logic              rx_en,
   output logic              irq
);
   logic [STAT_W-1:0] gate;
   logic              req;

   always_comb begin
      gate = '0;
      gate[B_TBE]  = tx_en;
      gate[B_TSBE] = tx_en;
      gate[B_RBF]  = rx_en;
      gate[B_SUM]  = rx_en;
   end

   assign req = |(stat & mask & gate);

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= req;
         end
      end else begin : g_comb
         assign irq = req;
         a_r11_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!tx_en && !rx_en) |-> !irq);
         a_r11_unmasked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (mask == '0) |-> !irq);
      end
   endgenerate
endmodule

// File: rtl/sir_uart_status.sv
module sir_uart_status
   import sir_uart_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int BUS_W   = 16,
   parameter int ADDR_W  = 3,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_sel,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              rx_stb,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              sh_take,
   input  logic              sh_done,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_byte,
   output logic              irq
);
   localparam int SEL_MAX = SEL_MASK;

   generate
      if (BUS_W < STAT_W || DATA_W > BUS_W || DATA_W < 1) begin : g_bad_width
         $error("sir_uart_status: BUS_W must hold the status bits and the data byte");
      end
      if ((1 << ADDR_W) <= SEL_MAX) begin : g_bad_addr
         $error("sir_uart_status: ADDR_W too small for the register map");
      end
   endgenerate

   logic              tx_en, rx_en;
   logic [STAT_W-1:0] mask_q;
   logic              wr_ctrl, wr_txd, wr_err, wr_mask, rd_clr;
   logic              tbe, tsbe, rbf;
   rx_err_t           err;
   logic [DATA_W-1:0] rx_hold;
   logic [STAT_W-1:0] stat;
   logic              unused_wdata;

   assign wr_ctrl = bus_wr && (bus_sel == ADDR_W'(SEL_CTRL));
   assign wr_txd  = bus_wr && (bus_sel == ADDR_W'(SEL_TXD));
   assign wr_err  = bus_wr && (bus_sel == ADDR_W'(SEL_ERRV));
   assign wr_mask = bus_wr && (bus_sel == ADDR_W'(SEL_MASK));
   assign rd_clr  = bus_rd && (bus_sel == ADDR_W'(SEL_RXD));
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en  <= 1'b0;
         rx_en  <= 1'b0;
         mask_q <= '0;
      end else begin
         if (wr_ctrl) begin
            tx_en <= bus_wdata[0];
            rx_en <= bus_wdata[1];
         end
         if (wr_mask) mask_q <= bus_wdata[STAT_W-1:0] & MASK_IMPL;
      end
   end

   sir_uart_tx_flags #(.DATA_W(DATA_W)) i_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_en    (tx_en),
      .tx_wr    (wr_txd),
      .tx_wdata (bus_wdata[DATA_W-1:0]),
      .tx_flush (wr_ctrl && bus_wdata[2]),
      .sh_take  (sh_take),
      .sh_done  (sh_done),
      .tbe      (tbe),
      .tsbe     (tsbe),
      .hold     (tx_byte)
   );

   sir_uart_rx_flags #(.DATA_W(DATA_W)) i_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_en    (rx_en),
      .rx_stb   (rx_stb),
      .rx_byte  (rx_byte),
      .par_in   (rx_par_err),
      .frm_in   (rx_frm_err),
      .rd_clr   (rd_clr),
      .err_wr   (wr_err),
      .err_keep (bus_wdata[B_OVR:B_PAR]),
      .rbf      (rbf),
      .err      (err),
      .hold     (rx_hold)
   );

   assign stat = {err.sum, err.ovr, err.frm, err.par, rbf, tsbe, tbe};

   sir_uart_irq #(.IRQ_REG(IRQ_REG)) i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (stat),
      .mask  (mask_q),
      .tx_en (tx_en),
      .rx_en (rx_en),
      .irq   (irq)
   );

   assign tx_valid = tx_en && !tbe;

   always_comb begin
      bus_rdata = '0;
      case (bus_sel)
         ADDR_W'(SEL_CTRL): bus_rdata[1:0] = {rx_en, tx_en};
         ADDR_W'(SEL_STAT): bus_rdata[STAT_W-1:0] = stat;
         ADDR_W'(SEL_ERRV): bus_rdata[B_SUM:B_PAR] = stat[B_SUM:B_PAR];
         ADDR_W'(SEL_RXD):  bus_rdata[DATA_W-1:0] = rx_hold;
         ADDR_W'(SEL_MASK): bus_rdata[STAT_W-1:0] = mask_q;
         default:           bus_rdata = '0;
      endcase
   end

   a_r6_sum_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == ADDR_W'(SEL_STAT)) |-> (bus_rdata[B_SUM] == |bus_rdata[B_OVR:B_PAR]));
   a_r1_no_full_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rbf) |-> $past(rx_stb && rx_en));
endmodule

// File: tb/test_sir_uart_status.sv
module test_sir_uart_status;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 22;

   typedef struct packed {
      logic        wr;
      logic        rd;
      logic [2:0]  sel;
      logic [15:0] wd;
      logic        rxs;
      logic [7:0]  rxb;
      logic        par;
      logic        frm;
      logic        take;
      logic        done;
      logic [6:0]  exp_stat;
      logic        exp_irq;
   } vec_t;

   // wr rd sel wd rxs rxb par frm take done stat irq
   localparam vec_t VECS [NV] = '{
      '{1,0,3'd0,16'h0003,0,8'h00,0,0,0,0,7'h03,0}, // R2 enable both
      '{1,0,3'd5,16'h0047,0,8'h00,0,0,0,0,7'h03,1}, // R11 tbe source
      '{1,0,3'd3,16'h0055,0,8'h00,0,0,0,0,7'h02,1}, // R3 load
      '{0,0,3'd1,16'h0000,0,8'h00,0,0,1,0,7'h01,1}, // R4 take
      '{1,0,3'd5,16'h0002,0,8'h00,0,0,0,0,7'h01,0}, // R11 shift-empty only
      '{0,0,3'd1,16'h0000,0,8'h00,0,0,0,1,7'h03,1}, // R4 done
      '{1,0,3'd5,16'h0004,0,8'h00,0,0,0,0,7'h03,0}, // R10 rbf only
      '{0,0,3'd1,16'h0000,1,8'hA5,0,0,0,0,7'h07,1}, // R5 byte
      '{0,0,3'd1,16'h0000,1,8'h3C,0,0,0,0,7'h67,1}, // R7 overrun
      '{0,1,3'd4,16'h0000,0,8'h00,0,0,0,0,7'h03,0}, // R8 read clears
      '{0,0,3'd1,16'h0000,1,8'h11,1,0,0,0,7'h4F,1}, // R6 parity
      '{1,0,3'd2,16'h0000,0,8'h00,0,0,0,0,7'h07,1}, // R9 clear errors
      '{0,0,3'd1,16'h0000,1,8'h22,0,1,0,0,7'h77,1}, // R7 overrun+frm
      '{1,0,3'd2,16'h0010,0,8'h00,0,0,0,0,7'h57,1}, // R9 keep frm
      '{1,0,3'd5,16'h0040,0,8'h00,0,0,0,0,7'h57,1}, // R11 sum source
      '{1,0,3'd0,16'h0001,0,8'h00,0,0,0,0,7'h57,0}, // R11 rx gate
      '{0,0,3'd1,16'h0000,1,8'h99,1,1,0,0,7'h57,0}, // R5 rx disabled
      '{0,1,3'd4,16'h0000,0,8'h00,0,0,0,0,7'h03,0}, // R8 clear
      '{1,0,3'd0,16'h0000,0,8'h00,0,0,0,0,7'h03,0}, // R2 all off
      '{1,0,3'd3,16'h0077,0,8'h00,0,0,0,0,7'h03,0}, // R3 ignored
      '{1,0,3'd0,16'h0001,0,8'h00,0,0,0,0,7'h03,0}, // R2 tx on
      '{1,0,3'd3,16'h0077,0,8'h00,0,0,0,0,7'h02,0}  // R3 load
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_sel = 3'd1;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        rx_stb = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic        rx_par_err = 1'b0, rx_frm_err = 1'b0;
   logic        sh_take = 1'b0, sh_done = 1'b0;
   logic        tx_valid, irq;
   logic [7:0]  tx_byte;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sir_uart_status i_sir_uart_status (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
      .rx_frm_err(rx_frm_err), .sh_take(sh_take), .sh_done(sh_done),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      bus_wr = 0; bus_rd = 0; bus_sel = 3'd1; bus_wdata = '0;
      rx_stb = 0; rx_par_err = 0; rx_frm_err = 0; sh_take = 0; sh_done = 0;
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      bus_wr = v.wr; bus_rd = v.rd; bus_sel = v.sel; bus_wdata = v.wd;
      rx_stb = v.rxs; rx_byte = v.rxb; rx_par_err = v.par; rx_frm_err = v.frm;
      sh_take = v.take; sh_done = v.done;
      @(negedge clk);
      idle();
      #1;
   endtask

   task automatic peek(input logic [2:0] s, output logic [15:0] d);
      bus_sel = s;
      #1;
      d = bus_rdata;
      bus_sel = 3'd1;
      #1;
   endtask

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      // R1 reset state
      peek(3'd0, d); check("R1 ctrl", d, 16'h0000);
      peek(3'd1, d); check("R1 status", d, 16'h0003);
      peek(3'd5, d); check("R1 mask", d, 16'h0000);
      check("R1 irq", {15'b0, irq}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         peek(3'd1, d);
         check($sformatf("vector %0d status", i), d, {9'b0, VECS[i].exp_stat});
         check($sformatf("vector %0d irq R11", i), {15'b0, irq}, {15'b0, VECS[i].exp_irq});
      end
      // R3 held byte is presented
      check("R3 tx_valid", {15'b0, tx_valid}, 16'h0001);
      check("R3 tx_byte", {8'b0, tx_byte}, 16'h0077);

      // R2 flush: bit 2 discards, reads back 0
      apply('{1,0,3'd0,16'h0007,0,8'h00,0,0,0,0,7'h03,0});
      peek(3'd1, d); check("R2 flush sets tbe", d, 16'h0003);
      peek(3'd0, d); check("R2 ctrl readback", d, 16'h0003);
      check("R2 tx_valid after flush", {15'b0, tx_valid}, 16'h0000);

      // R10 mask implemented bits
      apply('{1,0,3'd5,16'hFFFF,0,8'h00,0,0,0,0,7'h03,0});
      peek(3'd5, d); check("R10 mask readback", d, 16'h0047);

      // R7 old byte kept on overrun, R9 mirror view
      apply('{0,0,3'd1,16'h0000,1,8'hA5,0,0,0,0,7'h07,0});
      apply('{0,0,3'd1,16'h0000,1,8'h3C,0,1,0,0,7'h77,0});
      peek(3'd4, d); check("R7 old byte kept", d, 16'h00A5);
      peek(3'd2, d); check("R9 error view", d, 16'h0070);
      check("R11 irq rbf", {15'b0, irq}, 16'h0001);

      // R8 read in same cycle as new byte
      apply('{0,1,3'd4,16'h0000,1,8'h5A,0,0,0,0,7'h07,0});
      peek(3'd1, d); check("R8 read+new status", d, 16'h0007);
      peek(3'd4, d); check("R8 read+new byte", d, 16'h005A);

      // R4 take and write collide: write wins; take and done: take wins
      apply('{1,0,3'd3,16'h00C3,0,8'h00,0,0,1,1,7'h07,0});
      peek(3'd1, d); check("R4 collision status", d, 16'h0004);
      check("R3 tx_byte C3", {8'b0, tx_byte}, 16'h00C3);

      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule